// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block selects the operating mode of a small microcontroller and drives the controls that follow from it. The modes are full-speed active, subclock sleep (CPU halted, peripherals running from the subclock), subclock run (CPU running from a divided watch clock with the main oscillator stopped) and watch. Two further states cover an external reset pin. In RESET_HOLD the pin is held low. In RESET_WAIT the pin has been released but the main oscillator is not yet stable. From its state the block drives a CPU halt, the main oscillator enable, a clock gate for the serial bus peripheral, a one-cycle exception-start pulse and the divide select for the subclock.

A sleep strobe from the CPU takes the block out of a running state, and the target state is decoded from five mode-control bits. A qualified interrupt wakes the block from either halted low-power state into subclock run. An interrupt qualifies only when the global mask is clear and at least one source both requests and is enabled. The subclock divide field is copied into a shadow register only when a sleep strobe is taken. A change to the field therefore has no effect until the next sleep.

States: ST_ACTIVE, ST_SUBSLEEP, ST_SUBACTIVE, ST_WATCH, ST_RST_HOLD, ST_RST_WAIT. Transitions:
- ACTIVE or SUBACTIVE to the decoded target on a sleep strobe.
- SUBSLEEP or WATCH to SUBACTIVE on a qualified wake.
- Any state to RST_HOLD while the pin is low.
- RST_HOLD to RST_WAIT when the pin is high and the oscillator is unstable.
- RST_HOLD or RST_WAIT to ACTIVE once the pin is high and the oscillator is stable.

Top module: `pwr_mode_seq`

## Requirements
- R1: After the synchronous reset `rst_n` is released, the block is in ACTIVE: `cpu_halt`=0, `osc_main_en`=1, `serif_clk_en`=1, `exc_start`=0, `sub_div`=00.
- R2: In SUBSLEEP or WATCH, a qualified wake moves the block to SUBACTIVE at the next edge. In the same cycle `exc_start` is 1, and it is 0 again one cycle later.
- R3: A wake qualifies only when `irq_mask`=0 and some index i has both `irq_req[i]`=1 and `irq_en[i]`=1. Otherwise SUBSLEEP is held and `exc_start` stays 0.
- R4: A sleep strobe in ACTIVE or SUBACTIVE chooses the next state from the mode-control bits, with the first matching rule winning. The rules are, in order:
  1. `cfg_stby`=0 and `cfg_lowspd`=1 give SUBSLEEP.
  2. `cfg_stby`=1 and `cfg_watch_en`=1 give WATCH.
  3. `cfg_direct`=1 and `cfg_main_sel`=1 give ACTIVE.
  4. Any other combination gives SUBSLEEP.
- R5: The outputs {`cpu_halt`,`osc_main_en`,`serif_clk_en`} are set by the state: ACTIVE 011, SUBSLEEP 100, SUBACTIVE 000, WATCH 100, RST_HOLD and RST_WAIT 110.
- R6: `sub_div` follows `div_sel` only at a sleep strobe taken in ACTIVE or SUBACTIVE, and holds its value at every other edge. The encoding is 00=/1, 01=/2, 10=/4, 11=/8.
- R7: While `rst_pin_n`=0, the block enters or stays in RST_HOLD, the main oscillator is on and `sub_div` is cleared to 00. This takes priority over a sleep strobe or a wake in the same cycle.
- R8: After the pin goes high, `exc_start` pulses on entry to ACTIVE. Entry happens only at an edge where `stab_done`=1, and `exc_start` stays 0 while the oscillator is unstable.
- R9: `stab_wait` is 1 exactly when `osc_main_en`=1 and `stab_done`=0.
- R10: A sleep strobe in SUBSLEEP or WATCH is ignored: the state and `sub_div` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| sleep_stb | input | 1 | One-cycle sleep request from the CPU |
| cfg_stby | input | 1 | Mode-control: standby select |
| cfg_lowspd | input | 1 | Mode-control: low-speed on |
| cfg_watch_en | input | 1 | Mode-control: watch enable |
| cfg_direct | input | 1 | Mode-control: direct transfer |
| cfg_main_sel | input | 1 | Mode-control: main clock select |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks all wakes |
| irq_req | input | N_IRQ | Per-source interrupt requests |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| rst_pin_n | input | 1 | External reset pin, active low, already synchronised |
| stab_done | input | 1 | Oscillator stabilization timer expired |
| div_sel | input | 2 | Requested subclock divide field |
| cpu_halt | output | 1 | Halts the CPU |
| osc_main_en | output | 1 | Main oscillator enable |
| serif_clk_en | output | 1 | Clock gate for the serial bus peripheral |
| exc_start | output | 1 | One-cycle exception-handling start pulse |
| stab_wait | output | 1 | Oscillator on but not yet stable |
| sub_div | output | 2 | Applied subclock divide select |

## Verification
The assertions assume three things about the inputs:
- `rst_pin_n` and `stab_done` are synchronous to `clk`.
- `sleep_stb` is a single-cycle strobe.
- The interrupt inputs are sampled as steady levels, with no glitches between edges.

The bench drives every input on the falling edge, so each input is stable at the rising edge that samples it. It pulses the sleep strobe for exactly one cycle. It raises and lowers `stab_done` only between whole cycles, never at the moment the pin is released.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    localparam int DIV_W = 2;

    typedef enum logic [2:0] {
        ST_ACTIVE    = 3'd0,
        ST_SUBSLEEP  = 3'd1,
        ST_SUBACTIVE = 3'd2,
        ST_WATCH     = 3'd3,
        ST_RST_HOLD  = 3'd4,
        ST_RST_WAIT  = 3'd5
    } pms_state_t;

    typedef enum logic [1:0] {
        TGT_SUBSLEEP = 2'd0,
        TGT_WATCH    = 2'd1,
        TGT_ACTIVE   = 2'd2
    } pms_target_t;

    typedef struct packed {
        logic halt;
        logic osc_en;
        logic serif_en;
    } pms_ctrl_t;

endpackage

// File: rtl/pms_wake_qual.sv
module pms_wake_qual #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             irq_mask,
    output logic             wake_ok
);
    logic [N_IRQ-1:0] hit;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_src
        assign hit[i] = irq_req[i] & irq_en[i];
    end

    assign wake_ok = (|hit) & ~irq_mask;
endmodule

// File: rtl/pms_mode_decode.sv
module pms_mode_decode
    import pwr_mode_pkg::*;
(
    input  logic        cfg_stby,
    input  logic        cfg_lowspd,
    input  logic        cfg_watch_en,
    input  logic        cfg_direct,
    input  logic        cfg_main_sel,
    output pms_target_t target
);
    // R4: rules checked in priority order, first match wins
    always_comb begin
        if (!cfg_stby && cfg_lowspd) begin
            target = TGT_SUBSLEEP;
        end else if (cfg_stby && cfg_watch_en) begin
            target = TGT_WATCH;
        end else if (cfg_direct && cfg_main_sel) begin
            target = TGT_ACTIVE;
        end else begin
            target = TGT_SUBSLEEP;
        end
    end
endmodule

// File: rtl/pms_div_shadow.sv
module pms_div_shadow
    import pwr_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [DIV_W-1:0] din,
    output logic [DIV_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

    // R6: without a load or clear, the applied divider never moves
    a_r6_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load) |=> $stable(q));

    // R7: the pin reset clears the shadow to divide-by-one
    a_r7_div_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_stb,
    input  logic             cfg_stby,
    input  logic             cfg_lowspd,
    input  logic             cfg_watch_en,
    input  logic             cfg_direct,
    input  logic             cfg_main_sel,
    input  logic             irq_mask,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             rst_pin_n,
    input  logic             stab_done,
    input  logic [DIV_W-1:0] div_sel,
    output logic             cpu_halt,
    output logic             osc_main_en,
    output logic             serif_clk_en,
    output logic             exc_start,
    output logic             stab_wait,
    output logic [DIV_W-1:0] sub_div
);
    pms_state_t  st_q, st_d;
    pms_target_t target;
    pms_ctrl_t   ctrl;
    logic        wake_ok;
    logic        exc_d;
    logic        in_run;
    logic        div_load;

    pms_wake_qual #(.N_IRQ(N_IRQ)) i_wake (
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .irq_mask (irq_mask),
        .wake_ok  (wake_ok)
    );

    pms_mode_decode i_dec (
        .cfg_stby     (cfg_stby),
        .cfg_lowspd   (cfg_lowspd),
        .cfg_watch_en (cfg_watch_en),
        .cfg_direct   (cfg_direct),
        .cfg_main_sel (cfg_main_sel),
        .target       (target)
    );

    assign in_run   = (st_q == ST_ACTIVE) || (st_q == ST_SUBACTIVE);
    assign div_load = sleep_stb && in_run && rst_pin_n;

    pms_div_shadow i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!rst_pin_n),
        .load  (div_load),
        .din   (div_sel),
        .q     (sub_div)
    );

    // next state
    always_comb begin
        st_d  = st_q;
        exc_d = 1'b0;
        if (!rst_pin_n) begin
            st_d = ST_RST_HOLD;
        end else begin
            unique case (st_q)
                ST_ACTIVE, ST_SUBACTIVE: begin
                    if (sleep_stb) begin
                        unique case (target)
                            TGT_WATCH:  st_d = ST_WATCH;
                            TGT_ACTIVE: st_d = ST_ACTIVE;
                            default:    st_d = ST_SUBSLEEP;
                        endcase
                    end
                end
                ST_SUBSLEEP, ST_WATCH: begin
                    if (wake_ok) begin
                        st_d  = ST_SUBACTIVE;
                        exc_d = 1'b1;
                    end
                end
                ST_RST_HOLD: begin
                    if (stab_done) begin
                        st_d  = ST_ACTIVE;
                        exc_d = 1'b1;
                    end else begin
                        st_d = ST_RST_WAIT;
                    end
                end
                ST_RST_WAIT: begin
                    if (stab_done) begin
                        st_d  = ST_ACTIVE;
                        exc_d = 1'b1;
                    end
                end
                default: st_d = ST_ACTIVE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_ACTIVE;
            exc_start <= 1'b0;
        end else begin
            st_q      <= st_d;
            exc_start <= exc_d;
        end
    end

    // outputs per state
    always_comb begin
        unique case (st_q)
            ST_ACTIVE:                ctrl = '{halt: 1'b0, osc_en: 1'b1, serif_en: 1'b1};
            ST_SUBSLEEP, ST_WATCH:    ctrl = '{halt: 1'b1, osc_en: 1'b0, serif_en: 1'b0};
            ST_SUBACTIVE:             ctrl = '{halt: 1'b0, osc_en: 1'b0, serif_en: 1'b0};
            ST_RST_HOLD, ST_RST_WAIT: ctrl = '{halt: 1'b1, osc_en: 1'b1, serif_en: 1'b0};
            default:                  ctrl = '{halt: 1'b0, osc_en: 1'b1, serif_en: 1'b1};
        endcase
    end

    assign cpu_halt     = ctrl.halt;
    assign osc_main_en  = ctrl.osc_en;
    assign serif_clk_en = ctrl.serif_en;
    assign stab_wait    = ctrl.osc_en & ~stab_done;

    // R2: a qualified wake from a halted low-power state lands in subclock run with a pulse
    a_r2_wake_to_subactive: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SUBSLEEP || st_q == ST_WATCH) && rst_pin_n && !irq_mask
         && (|(irq_req & irq_en)))
        |=> (st_q == ST_SUBACTIVE && exc_start));

    // R2: the exception start is a single-cycle pulse
    a_r2_exc_single: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start |=> !exc_start);

    // R3: a masked interrupt never releases subclock sleep
    a_r3_masked_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SUBSLEEP && rst_pin_n && irq_mask) |=> (st_q == ST_SUBSLEEP && !exc_start));

    // R7: a low pin forces the oscillator on and the CPU halted
    a_r7_pin_osc_on: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pin_n |=> (osc_main_en && cpu_halt && !exc_start));

    // R8: no exception start while the oscillator is still settling
    a_r8_no_exc_unstable: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_RST_HOLD || st_q == ST_RST_WAIT) && !stab_done) |=> !exc_start);

    // R10: a sleep strobe in a halted state leaves the state alone
    a_r10_sleep_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WATCH && rst_pin_n && !wake_ok && sleep_stb) |=> (st_q == ST_WATCH));
endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
    localparam int N_IRQ = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sleep_stb;
    logic             cfg_stby, cfg_lowspd, cfg_watch_en, cfg_direct, cfg_main_sel;
    logic             irq_mask;
    logic [N_IRQ-1:0] irq_req, irq_en;
    logic             rst_pin_n;
    logic             stab_done;
    logic [1:0]       div_sel;
    logic             cpu_halt, osc_main_en, serif_clk_en, exc_start, stab_wait;
    logic [1:0]       sub_div;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pwr_mode_seq #(.N_IRQ(N_IRQ)) i_pwr_mode_seq (
        .clk(clk), .rst_n(rst_n), .sleep_stb(sleep_stb),
        .cfg_stby(cfg_stby), .cfg_lowspd(cfg_lowspd), .cfg_watch_en(cfg_watch_en),
        .cfg_direct(cfg_direct), .cfg_main_sel(cfg_main_sel),
        .irq_mask(irq_mask), .irq_req(irq_req), .irq_en(irq_en),
        .rst_pin_n(rst_pin_n), .stab_done(stab_done), .div_sel(div_sel),
        .cpu_halt(cpu_halt), .osc_main_en(osc_main_en), .serif_clk_en(serif_clk_en),
        .exc_start(exc_start), .stab_wait(stab_wait), .sub_div(sub_div)
    );

    // expected {halt, osc, serif} codes
    localparam logic [2:0] M_ACTIVE = 3'b011;
    localparam logic [2:0] M_SLEEP  = 3'b100;
    localparam logic [2:0] M_SUBRUN = 3'b000;
    localparam logic [2:0] M_RST    = 3'b110;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_mode(input string req, input logic [2:0] exp);
        check(req, "mode", 8'({cpu_halt, osc_main_en, serif_clk_en}), 8'(exp));
    endtask

    // cfg order: {stby, lowspd, watch_en, direct, main_sel}
    task automatic do_sleep(input logic [4:0] cfg, input logic [1:0] dv);
        {cfg_stby, cfg_lowspd, cfg_watch_en, cfg_direct, cfg_main_sel} = cfg;
        div_sel   = dv;
        sleep_stb = 1'b1;
        step();
        sleep_stb = 1'b0;
    endtask

    task automatic do_wake(input int src);
        irq_req      = '0;
        irq_en       = '0;
        irq_req[src] = 1'b1;
        irq_en[src]  = 1'b1;
        step();
        irq_req = '0;
        irq_en  = '0;
    endtask

    task automatic go_active();
        stab_done = 1'b1;
        rst_pin_n = 1'b0;
        step();
        rst_pin_n = 1'b1;
        step();
        step();
    endtask

    task automatic t_reset();
        chk_mode("R1", M_ACTIVE);
        check("R1", "exc_start", 8'(exc_start), 8'd0);
        check("R1", "sub_div", 8'(sub_div), 8'd0);
        check("R9", "stab_wait active stable", 8'(stab_wait), 8'd0);
    endtask

    task automatic t_decode();
        do_sleep(5'b01000, 2'd0);
        chk_mode("R4", M_SLEEP);
        do_wake(0);
        chk_mode("R2", M_SUBRUN);
        check("R2", "exc_start wake", 8'(exc_start), 8'd1);
        step();
        check("R2", "exc_start drop", 8'(exc_start), 8'd0);
        do_sleep(5'b10011, 2'd0);
        chk_mode("R4", M_ACTIVE);
        do_sleep(5'b10100, 2'd0);
        chk_mode("R5", M_SLEEP);
        do_wake(6);
        chk_mode("R2", M_SUBRUN);
        check("R2", "exc_start from watch", 8'(exc_start), 8'd1);
        do_sleep(5'b01011, 2'd0);
        chk_mode("R4", M_SLEEP);
        do_wake(1);
        do_sleep(5'b00000, 2'd0);
        chk_mode("R4", M_SLEEP);
    endtask

    task automatic t_nowake();
        irq_mask = 1'b1;
        irq_req  = 8'hFF;
        irq_en   = 8'hFF;
        step();
        step();
        chk_mode("R3", M_SLEEP);
        check("R3", "exc_start masked", 8'(exc_start), 8'd0);
        irq_mask = 1'b0;
        irq_req  = 8'h08;
        irq_en   = 8'h20;
        step();
        step();
        chk_mode("R3", M_SLEEP);
        check("R3", "exc_start unmatched", 8'(exc_start), 8'd0);
        irq_req = 8'h20;
        step();
        irq_req = '0;
        irq_en  = '0;
        chk_mode("R3", M_SUBRUN);
    endtask

    task automatic t_div();
        go_active();
        div_sel = 2'd2;
        step();
        check("R6", "sub_div no strobe", 8'(sub_div), 8'd0);
        do_sleep(5'b01000, 2'd2);
        check("R6", "sub_div latched", 8'(sub_div), 8'd2);
        do_sleep(5'b10100, 2'd3);
        chk_mode("R10", M_SLEEP);
        check("R10", "sub_div in sleep", 8'(sub_div), 8'd2);
        do_wake(2);
        check("R6", "sub_div after wake", 8'(sub_div), 8'd2);
        do_sleep(5'b00011, 2'd1);
        chk_mode("R4", M_ACTIVE);
        check("R6", "sub_div relatched", 8'(sub_div), 8'd1);
    endtask

    task automatic t_pin();
        do_sleep(5'b01000, 2'd3);
        do_wake(4);
        check("R6", "sub_div div8", 8'(sub_div), 8'd3);
        stab_done = 1'b0;
        step();
        check("R9", "stab_wait osc off", 8'(stab_wait), 8'd0);
        rst_pin_n = 1'b0;
        sleep_stb = 1'b1;
        step();
        sleep_stb = 1'b0;
        chk_mode("R7", M_RST);
        check("R7", "sub_div cleared", 8'(sub_div), 8'd0);
        check("R9", "stab_wait unstable", 8'(stab_wait), 8'd1);
        step();
        chk_mode("R7", M_RST);
        rst_pin_n = 1'b1;
        step();
        check("R8", "exc_start unstable", 8'(exc_start), 8'd0);
        step();
        chk_mode("R8", M_RST);
        check("R8", "exc_start still", 8'(exc_start), 8'd0);
        stab_done = 1'b1;
        step();
        chk_mode("R8", M_ACTIVE);
        check("R8", "exc_start release", 8'(exc_start), 8'd1);
        check("R9", "stab_wait stable", 8'(stab_wait), 8'd0);
        step();
        check("R8", "exc_start drop", 8'(exc_start), 8'd0);
    endtask

    initial begin
        rst_n = 1'b0; sleep_stb = 1'b0;
        {cfg_stby, cfg_lowspd, cfg_watch_en, cfg_direct, cfg_main_sel} = '0;
        irq_mask = 1'b0; irq_req = '0; irq_en = '0;
        rst_pin_n = 1'b1; stab_done = 1'b1; div_sel = 2'd0;
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_decode();
        t_nowake();
        t_div();
        t_pin();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule